// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous burst SRAM that accepts a read or a write on every enabled clock edge. It inserts no idle cycle when the traffic switches between reads and writes. Address and command inputs are registered on the rising edge. Read data then flows combinationally from the registered address onto the output bus in the same cycle. Write data follows one enabled edge after its command. It is parked in a one-entry buffer and lands in the array on the next enabled edge. A read that arrives while a write is still parked is served the merged new bytes.

The data bus is split into an input, an output and an output-enable. The block releases the bus on its own while a write's data is due. An asynchronous output-enable can also release it. A clock-enable freezes the whole block, a sleep input blocks new commands, and three chip selects must all be active to start an access. A two-bit burst counter walks four addresses in linear or interleaved order.

Top module: `zbt_flow_sram`

## Requirements
- R1: After reset the block holds no access in progress and `dq_oe` is 0.
- R2: A load (`adv`=0) starts an access only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination is a deselect, and `dq_oe` is 0 in the following cycle.
- R3: A read loaded on an edge drives the stored word on `dq_o` with `dq_oe`=1 in the cycle right after that same edge, with no further register stage.
- R4: A write (`wr_n`=0) takes `dq_i` on the next enabled edge after its command. Byte b of the word is bits [9b+8:9b] and is updated only if `byte_en_n[b]`=0 on the command edge. The other bytes keep their value.
- R5: In the cycle after a write command edge, which is the write's data phase, `dq_oe` is 0 whatever `out_en_n` is.
- R6: Reads and writes may follow each other on consecutive edges in any pattern. A read of the address of a write whose data is still buffered returns the new bytes merged with the array's stored bytes.
- R7: An edge with `clk_en`=0 is ignored. State, pending write data and outputs keep their values, and the command presented on that edge has no effect.
- R8: `out_en_n`=1 forces `dq_oe` to 0 combinationally, without waiting for a clock edge.
- R9: An advance (`adv`=1) keeps the type of the access that opened the burst and ignores the chip selects and `wr_n`. It steps a 2-bit count c that wraps after 3. The low two address bits are (start+c) mod 4 when `burst_ilv`=0 and start XOR c when `burst_ilv`=1.
- R10: While `sleep`=1 no command is accepted, no write is stored, and `dq_oe` is 0 at once.
- R11: An advance that follows a deselect stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | 1 lets an edge act; 0 stalls the block |
| sleep | input | 1 | Power-down: blocks commands and output drive |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr_n | input | 1 | 0 = write, 1 = read (on load) |
| byte_en_n | input | BYTES | Per-byte write select, active low |
| addr | input | ADDR_W | Word address for a load |
| burst_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | BYTES*BYTE_W | Write data from the bus |
| dq_o | output | BYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | 1 when the block drives the bus |

## Verification
The assertions follow the control register and the write buffer on every cycle. They check that a deselect or sleep edge leaves no access open and that a stalled edge changes nothing. They also check that an advance keeps the burst type and steps the count, that a write command is always followed by a buffered write, and that the buffer drains when no new write arrives. Only the bench's scenarios can show the data values. These are the forwarded and merged bytes after back-to-back write and read, the linear and interleaved address walk and its wrap, and the word seen after a stalled or sleeping write command was ignored. The scenarios also cover the combinational release of the bus by the output enable and by sleep.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits for burst beat cnt starting at start
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/zbt_burst_addr.sv
`timescale 1ns/1ps
module zbt_burst_addr #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        cnt,
    input  logic              ilv,
    output logic [ADDR_W-1:0] eff
);
    import zbt_pkg::*;

    always_comb begin
        eff      = base;
        eff[1:0] = burst_low(base[1:0], cnt, ilv);
    end

endmodule

// File: rtl/zbt_mem_array.sv
`timescale 1ns/1ps
module zbt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES-1:0]        wmask,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    // One storage lane per byte so each byte select gates its own write
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[b]) begin
                lane_q[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_q[raddr];
    end

endmodule

// File: rtl/zbt_wr_buffer.sv
`timescale 1ns/1ps
module zbt_wr_buffer #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    cap,
    input  logic [ADDR_W-1:0]       cap_addr,
    input  logic [BYTES-1:0]        cap_mask,
    input  logic [BYTES*BYTE_W-1:0] cap_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [BYTES*BYTE_W-1:0] arr_rdata,
    output logic [BYTES*BYTE_W-1:0] fwd_rdata,
    output logic                    cmt_we,
    output logic [ADDR_W-1:0]       cmt_addr,
    output logic [BYTES-1:0]        cmt_mask,
    output logic [BYTES*BYTE_W-1:0] cmt_data
);
    localparam int DW = BYTES * BYTE_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  mask;
        logic [DW-1:0]     data;
    } wb_t;

    wb_t  wb_d, wb_q;
    logic hit;

    always_comb begin
        wb_d = wb_q;
        if (clk_en) begin
            wb_d.valid = cap;
            if (cap) begin
                wb_d.addr = cap_addr;
                wb_d.mask = cap_mask;
                wb_d.data = cap_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    // The parked write moves into the array on the next enabled edge
    assign cmt_we   = clk_en && wb_q.valid;
    assign cmt_addr = wb_q.addr;
    assign cmt_mask = wb_q.mask;
    assign cmt_data = wb_q.data;

    assign hit = wb_q.valid && (wb_q.addr == rd_addr);

    for (genvar b = 0; b < BYTES; b++) begin : g_fwd
        assign fwd_rdata[b*BYTE_W +: BYTE_W] = (hit && wb_q.mask[b])
            ? wb_q.data[b*BYTE_W +: BYTE_W]
            : arr_rdata[b*BYTE_W +: BYTE_W];
    end

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cap) |=> (wb_q.valid && wb_q.addr == $past(cap_addr)
                             && wb_q.data == $past(cap_data)))
        else $error("write data not parked after its data edge");

    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !cap) |=> !wb_q.valid)
        else $error("buffer still holds a write after it committed");

endmodule

// File: rtl/zbt_flow_sram.sv
`timescale 1ns/1ps
module zbt_flow_sram #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    sleep,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    adv,
    input  logic                    wr_n,
    input  logic [BYTES-1:0]        byte_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_ilv,
    input  logic                    out_en_n,
    input  logic [BYTES*BYTE_W-1:0] dq_i,
    output logic [BYTES*BYTE_W-1:0] dq_o,
    output logic                    dq_oe
);
    import zbt_pkg::*;

    localparam int DW = BYTES * BYTE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic [BYTES-1:0]  mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic selected;

    logic [ADDR_W-1:0] eff_addr;
    logic [DW-1:0]     arr_rdata;
    logic              cmt_we;
    logic [ADDR_W-1:0] cmt_addr;
    logic [BYTES-1:0]  cmt_mask;
    logic [DW-1:0]     cmt_data;

    assign selected = !sel1_n && sel2 && !sel3_n;

    always_comb begin
        ctl_d = ctl_q;
        if (clk_en) begin
            if (sleep) begin
                ctl_d.op  = OP_IDLE;
                ctl_d.cnt = '0;
            end else if (!adv) begin
                ctl_d.op   = selected ? (wr_n ? OP_RD : OP_WR) : OP_IDLE;
                ctl_d.base = addr;
                ctl_d.cnt  = '0;
                ctl_d.mask = ~byte_en_n;
            end else begin
                ctl_d.cnt  = ctl_q.cnt + 2'd1;
                ctl_d.mask = ~byte_en_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{op: OP_IDLE, base: '0, cnt: '0, mask: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    zbt_burst_addr #(.ADDR_W(ADDR_W)) u_baddr (
        .base (ctl_q.base),
        .cnt  (ctl_q.cnt),
        .ilv  (burst_ilv),
        .eff  (eff_addr)
    );

    zbt_wr_buffer #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .cap       (ctl_q.op == OP_WR),
        .cap_addr  (eff_addr),
        .cap_mask  (ctl_q.mask),
        .cap_data  (dq_i),
        .rd_addr   (eff_addr),
        .arr_rdata (arr_rdata),
        .fwd_rdata (dq_o),
        .cmt_we    (cmt_we),
        .cmt_addr  (cmt_addr),
        .cmt_mask  (cmt_mask),
        .cmt_data  (cmt_data)
    );

    zbt_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (cmt_we),
        .waddr (cmt_addr),
        .wmask (cmt_mask),
        .wdata (cmt_data),
        .raddr (eff_addr),
        .rdata (arr_rdata)
    );

    // Bus is driven only during a read's data phase
    assign dq_oe = (ctl_q.op == OP_RD) && !out_en_n && !sleep;

    assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && !adv && !selected) |=> (ctl_q.op == OP_IDLE))
        else $error("deselect edge opened an access");

    assert_write_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ctl_q.op == OP_WR) |=> (!clk_en || cmt_we))
        else $error("write data phase did not park a write");

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(ctl_q.op) && $stable(ctl_q.base) && $stable(ctl_q.cnt)))
        else $error("stalled edge changed control state");

    assert_burst_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv) |=> (ctl_q.op == $past(ctl_q.op)))
        else $error("advance changed the burst type");

    assert_burst_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv) |=> (ctl_q.cnt == $past(ctl_q.cnt) + 2'd1))
        else $error("advance did not step the burst count");

    assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sleep) |=> (ctl_q.op == OP_IDLE))
        else $error("command accepted during sleep");

endmodule

// File: tb/tb_zbt_flow_sram.sv
`timescale 1ns/1ps
module tb_zbt_flow_sram;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam logic [DW-1:0] JUNK = 18'h2A5A5;

    // en adv s1n s2 s3n wrn ben addr | drv wd | ez ex | req
    typedef struct packed {
        logic          en;
        logic          adv;
        logic          s1n;
        logic          s2;
        logic          s3n;
        logic          wrn;
        logic [1:0]    ben;
        logic [5:0]    a;
        logic          drv;
        logic [DW-1:0] wd;
        logic          ez;
        logic [DW-1:0] ex;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,6'h05,1'b1,18'h12345,1'b1,18'h00000,4'd5},  // R5 write A5
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h05,1'b0,JUNK,     1'b0,18'h12345,4'd6},  // R6 forwarded
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b10,6'h05,1'b1,18'h3FFFF,1'b1,18'h00000,4'd5},  // R5 byte0 write
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h05,1'b0,JUNK,     1'b0,18'h123FF,4'd4},  // R4 merge
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,6'h06,1'b1,18'h0ABCD,1'b1,18'h00000,4'd5},  // R5
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,6'h07,1'b1,18'h2BEEF,1'b1,18'h00000,4'd6},  // R6 w-w
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h06,1'b1,18'h2BEEF,1'b1,18'h00000,4'd7},  // R7 stall in data phase
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h07,1'b0,JUNK,     1'b0,18'h2BEEF,4'd6},  // R6
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h06,1'b0,JUNK,     1'b0,18'h0ABCD,4'd3},  // R3
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,6'h05,1'b0,JUNK,     1'b0,18'h0ABCD,4'd7},  // R7 hold
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,6'h06,1'b0,JUNK,     1'b1,18'h00000,4'd2},  // R2 sel2 off
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,2'b00,6'h06,1'b0,JUNK,     1'b1,18'h00000,4'd2},  // R2 sel1 off
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,2'b00,6'h06,1'b0,JUNK,     1'b1,18'h00000,4'd2},  // R2 sel3 off
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h05,1'b0,JUNK,     1'b0,18'h123FF,4'd3},  // R3, R7 write ignored
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,6'h12,1'b1,18'h00011,1'b1,18'h00000,4'd9},  // R9 burst write
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,6'h00,1'b1,18'h00022,1'b1,18'h00000,4'd9},  // R9 -> 13
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,6'h00,1'b1,18'h00033,1'b1,18'h00000,4'd9},  // R9 -> 10
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,6'h00,1'b1,18'h00044,1'b1,18'h00000,4'd9},  // R9 -> 11
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h11,1'b0,JUNK,     1'b0,18'h00044,4'd6},  // R6
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h13,1'b0,JUNK,     1'b0,18'h00022,4'd9},  // R9 read burst
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,6'h00,1'b0,JUNK,     1'b0,18'h00033,4'd9},  // R9 wr_n ignored
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,6'h00,1'b0,JUNK,     1'b0,18'h00044,4'd9},  // R9
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,6'h00,1'b0,JUNK,     1'b0,18'h00011,4'd9},  // R9
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,6'h00,1'b0,JUNK,     1'b0,18'h00022,4'd9},  // R9 wrap
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,6'h08,1'b1,18'h15555,1'b1,18'h00000,4'd5},  // R5
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h06,1'b0,JUNK,     1'b0,18'h0ABCD,4'd6},  // R6 no false hit
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,6'h08,1'b0,JUNK,     1'b0,18'h15555,4'd4},  // R4 committed
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,6'h00,1'b0,JUNK,     1'b1,18'h00000,4'd2}   // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          sleep = 1'b0;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic          adv = 1'b0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] byte_en_n = '1;
    logic [AW-1:0] addr = '0;
    logic          burst_ilv = 1'b0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] dq_i = JUNK;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    zbt_flow_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv(adv), .wr_n(wr_n),
        .byte_en_n(byte_en_n), .addr(addr), .burst_ilv(burst_ilv),
        .out_en_n(out_en_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic check(input string tag, input logic ez, input logic [DW-1:0] ex);
        n_chk++;
        if (ez) begin
            if (dq_oe !== 1'b0) begin
                n_fail++;
                $display("FAIL %s: oe=%b expected oe=0", tag, dq_oe);
            end
        end else if (dq_oe !== 1'b1 || dq_o !== ex) begin
            n_fail++;
            $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", tag, dq_oe, dq_o, ex);
        end
    endtask

    // Apply controls at a falling edge, pass one rising edge, return at the next falling edge
    task automatic issue(input logic e, input logic a_v, input logic s1, input logic s2v,
                         input logic s3, input logic w, input logic [NB-1:0] be,
                         input logic [AW-1:0] ad);
        clk_en = e; adv = a_v; sel1_n = s1; sel2 = s2v; sel3_n = s3;
        wr_n = w; byte_en_n = be; addr = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run still active, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset idle", 1'b1, '0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].en, VEC[i].adv, VEC[i].s1n, VEC[i].s2, VEC[i].s3n,
                  VEC[i].wrn, VEC[i].ben, VEC[i].a);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].ez, VEC[i].ex);
            dq_i = VEC[i].drv ? VEC[i].wd : JUNK;
        end
        dq_i = JUNK;

        // R8: output enable releases and restores the bus without a clock edge
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 6'h05);
        check("R8 read before oe", 1'b0, 18'h123FF);
        out_en_n = 1'b1;
        #0.2;
        check("R8 oe released", 1'b1, '0);
        out_en_n = 1'b0;
        #0.2;
        check("R8 oe restored", 1'b0, 18'h123FF);

        // R9: interleaved walk from low bits 3: 13, 12, 11, 10
        burst_ilv = 1'b1;
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 6'h13);
        check("R9 ilv beat0", 1'b0, 18'h00022);
        issue(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 6'h00);
        check("R9 ilv beat1", 1'b0, 18'h00011);
        issue(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 6'h00);
        check("R9 ilv beat2", 1'b0, 18'h00044);
        issue(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 6'h00);
        check("R9 ilv beat3", 1'b0, 18'h00033);
        burst_ilv = 1'b0;

        // R10: sleep blocks a read and a write, and gates the bus at once
        sleep = 1'b1;
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 6'h05);
        check("R10 sleep read", 1'b1, '0);
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 6'h05);
        check("R10 sleep write", 1'b1, '0);
        dq_i = 18'h00000;
        sleep = 1'b0;
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 6'h05);
        dq_i = JUNK;
        check("R10 write ignored", 1'b0, 18'h123FF);
        sleep = 1'b1;
        #0.2;
        check("R10 sleep gates bus", 1'b1, '0);
        sleep = 1'b0;

        // R11: advance after deselect stays deselected
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 6'h05);
        check("R11 deselect", 1'b1, '0);
        issue(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 6'h05);
        check("R11 advance idle", 1'b1, '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule